// File: doc/BRIEF.md
# DMA Channel Idle-Wait Counter

This block measures, for one DMA channel, how long the channel has been without bus ownership. A single 16-bit down-counter serves two roles, and a mode input picks between them. In device-request mode the counter is a slow stall watchdog. A divide-by-64 prescaler paces it, and when it runs out a sticky stall flag is raised. Software clears the flag by writing 1. In memory-transfer mode the same counter is a re-request delay timer that counts every clock. When it runs out, the channel raises its bus request.

Two events start a measurement. The first is a one-cycle pulse marking the cycle in which the channel gives up the bus. The second is a level input telling the block that the channel holds the bus. While that level is high, the measurement is frozen and then ended. The counter value is visible as a read-only output.

Top module: `dma_idle_wait_counter`

## Requirements
- R1: After reset the counter reads 0x0000, the stall flag is 0 and the bus request is 0.
- R2: In device-request mode (`io_mode` = 1) with the bus not held, the counter decreases by one once every 64 clock cycles.
- R3: In device-request mode a release pulse loads the counter with `stall_interval` bits [21:6] on the next edge, and it restarts the 64-cycle prescaler, so the measurement always begins at the release.
- R4: In device-request mode, with a load value L ≥ 1, the stall flag rises exactly 64·L edges after the release edge. On that edge the counter returns to L, and it stays at L while the flag is set.
- R5: A flag write with `clr_wr` = 1 and `clr_data` = 1 clears the flag on that edge. With `clr_data` = 0 the write has no effect. If a clearing write arrives on the same edge as a new stall detection, the flag stays set.
- R6: After the flag is cleared, counting resumes from L, and the next stall is flagged 64·L edges after the clearing edge.
- R7: In memory-transfer mode (`io_mode` = 0) a release loads `req_delay`. The counter then decreases by one on every clock while the bus is not held, and it stops at 0.
- R8: In memory-transfer mode `bus_req` is 1 while the counter is 0 after a release and the bus is not held. A delay of 0 gives the request in the cycle right after the release. `bus_req` is never 1 in device-request mode.
- R9: While `bus_grant` is 1, `bus_req` is 0 in that same cycle and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_mode | input | 1 | 1 = device-request (stall watchdog), 0 = memory-transfer (delay timer) |
| stall_interval | input | 22 | Stall interval in clock cycles; bits [21:6] form the counter load |
| req_delay | input | 16 | Re-request delay in clock cycles for memory-transfer mode |
| own_release | input | 1 | One-cycle pulse: the channel has released the bus |
| bus_grant | input | 1 | Level: the channel currently holds the bus |
| clr_wr | input | 1 | Write strobe for the stall flag |
| clr_data | input | 1 | Data bit of that write; 1 clears the flag |
| wait_count | output | 16 | Current counter value |
| stall_flag | output | 1 | Sticky stall-detected flag |
| bus_req | output | 1 | Bus-ownership request in memory-transfer mode |

## Verification
The watchdog mode is driven with a plain release-then-wait pattern, which shows whether the 64-cycle pacing and the exact stall edge are right. A second release arrives partway through a prescaler period, which separates a prescaler that restarts on release from one that runs freely. Flag writes come with data 0, with data 1, and with data 1 on the very edge of a new stall. These tell apart a correct write-1-to-clear, a write-any-to-clear, and a clear that wrongly overrides detection. In delay mode a nonzero delay, a zero delay and a grant arriving mid-count show the per-cycle decrement, the request made the next cycle, and the freeze while the bus is held.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  typedef enum logic {
    MODE_MEM = 1'b0,
    MODE_IO  = 1'b1
  } iwc_mode_e;
endpackage

// File: rtl/iwc_prescaler.sv
module iwc_prescaler #(
  parameter int LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  logic [LOG2-1:0] phase_q;

  assign tick = run && (phase_q == {LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else if (run)          phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/iwc_down_counter.sv
module iwc_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         is_zero,
  output logic         at_last
);
  logic [W-1:0] cnt_q;

  assign value   = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign at_last = (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (dec && !is_zero)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/iwc_stall_flag.sv
module iwc_stall_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr,
  input  logic wr_data,
  output logic flag
);
  logic flag_q;

  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (set)            flag_q <= 1'b1;
    else if (wr && wr_data)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/dma_idle_wait_counter.sv
module dma_idle_wait_counter
  import iwc_pkg::*;
#(
  parameter  int CNT_W      = 16,
  parameter  int PRESC_LOG2 = 6,
  localparam int IVL_W      = CNT_W + PRESC_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_mode,
  input  logic [IVL_W-1:0] stall_interval,
  input  logic [CNT_W-1:0] req_delay,
  input  logic             own_release,
  input  logic             bus_grant,
  input  logic             clr_wr,
  input  logic             clr_data,
  output logic [CNT_W-1:0] wait_count,
  output logic             stall_flag,
  output logic             bus_req
);
  function automatic logic [CNT_W-1:0] stall_reload(input logic [IVL_W-1:0] ivl);
    return ivl[IVL_W-1:PRESC_LOG2];
  endfunction

  function automatic logic [CNT_W-1:0] pick_load(input iwc_mode_e m,
                                                 input logic [IVL_W-1:0] ivl,
                                                 input logic [CNT_W-1:0] dly);
    return (m == MODE_IO) ? stall_reload(ivl) : dly;
  endfunction

  iwc_mode_e mode;
  logic      active_q;
  logic      io_run, mem_run;
  logic      tick_ev, stall_ev, reload_ev, mem_dec, cnt_load, cnt_dec;
  logic      cnt_zero, cnt_last;
  logic [CNT_W-1:0] load_val;

  assign mode      = iwc_mode_e'(io_mode);
  assign reload_ev = own_release;

  assign io_run  = (mode == MODE_IO) && active_q && !bus_grant && !stall_flag && !own_release;
  assign mem_run = (mode == MODE_MEM) && active_q && !bus_grant && !own_release;

  assign stall_ev = tick_ev && cnt_last;
  assign mem_dec  = mem_run && !cnt_zero;
  assign cnt_load = reload_ev || stall_ev;
  assign cnt_dec  = mem_dec || (tick_ev && !stall_ev);
  assign load_val = pick_load(mode, stall_interval, req_delay);

  assign bus_req = (mode == MODE_MEM) && active_q && !bus_grant && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)           active_q <= 1'b0;
    else if (own_release) active_q <= 1'b1;
    else if (bus_grant)   active_q <= 1'b0;
  end

  iwc_prescaler #(.LOG2(PRESC_LOG2)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cnt_load),
    .run     (io_run),
    .tick    (tick_ev)
  );

  iwc_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (load_val),
    .dec      (cnt_dec),
    .value    (wait_count),
    .is_zero  (cnt_zero),
    .at_last  (cnt_last)
  );

  iwc_stall_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (stall_ev),
    .wr      (clr_wr),
    .wr_data (clr_data),
    .flag    (stall_flag)
  );
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
  parameter int CNT_W      = 16,
  parameter int PRESC_LOG2 = 6,
  parameter int IVL_W      = CNT_W + PRESC_LOG2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_mode,
  input logic [IVL_W-1:0] stall_interval,
  input logic [CNT_W-1:0] req_delay,
  input logic             own_release,
  input logic             bus_grant,
  input logic             clr_wr,
  input logic             clr_data,
  input logic [CNT_W-1:0] wait_count,
  input logic             stall_flag,
  input logic             bus_req,
  input logic             active_q,
  input logic             tick_ev,
  input logic             stall_ev
);
  // R3
  io_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_release && io_mode |=> wait_count == $past(stall_interval[IVL_W-1:PRESC_LOG2]));

  // R7
  mem_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_release && !io_mode |=> wait_count == $past(req_delay));

  // R7
  mem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_mode && active_q && !bus_grant && !own_release && wait_count != '0
    |=> wait_count == CNT_W'($past(wait_count) - 1));

  // R2
  io_tick_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ev |-> io_mode && !bus_grant && !stall_flag);

  // R4
  stall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> stall_flag);

  // R4
  held_while_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_flag && !own_release |=> $stable(wait_count));

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_flag && !(clr_wr && clr_data) |=> stall_flag);

  // R5
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_data && !stall_ev |=> !stall_flag);

  // R8
  req_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !io_mode && wait_count == '0);

  // R9
  grant_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant && !own_release |=> $stable(wait_count));

  // R9
  grant_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !bus_req);
endmodule

bind dma_idle_wait_counter iwc_checker #(
  .CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2), .IVL_W(IVL_W)
) u_iwc_chk (
  .clk(clk), .rst_n(rst_n), .io_mode(io_mode), .stall_interval(stall_interval),
  .req_delay(req_delay), .own_release(own_release), .bus_grant(bus_grant),
  .clr_wr(clr_wr), .clr_data(clr_data), .wait_count(wait_count),
  .stall_flag(stall_flag), .bus_req(bus_req), .active_q(active_q),
  .tick_ev(tick_ev), .stall_ev(stall_ev)
);

// File: tb/test_dma_idle_wait_counter.sv
module test_dma_idle_wait_counter;
  localparam int CNT_W = 16;
  localparam int IVL_W = 22;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             io_mode;
  logic [IVL_W-1:0] stall_interval;
  logic [CNT_W-1:0] req_delay;
  logic             own_release, bus_grant, clr_wr, clr_data;
  logic [CNT_W-1:0] wait_count;
  logic             stall_flag, bus_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_idle_wait_counter i_dma_idle_wait_counter (
    .clk(clk), .rst_n(rst_n), .io_mode(io_mode), .stall_interval(stall_interval),
    .req_delay(req_delay), .own_release(own_release), .bus_grant(bus_grant),
    .clr_wr(clr_wr), .clr_data(clr_data), .wait_count(wait_count),
    .stall_flag(stall_flag), .bus_req(bus_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; io_mode = 1'b0; stall_interval = '0; req_delay = '0;
    own_release = 1'b0; bus_grant = 1'b0; clr_wr = 1'b0; clr_data = 1'b0;
    edges(3);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_release();
    @(negedge clk);
    own_release = 1'b1;
    edges(1);
    own_release = 1'b0;
  endtask

  task automatic flag_write(input logic d);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = d;
    edges(1);
    clr_wr = 1'b0; clr_data = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 count", 32'(wait_count), 0);
    check("R1 flag", 32'(stall_flag), 0);
    check("R1 req", 32'(bus_req), 0);
  endtask

  // L = 3, stall after 192 edges
  task automatic t_io_stall();
    do_reset();
    io_mode = 1'b1; stall_interval = 22'd192;
    pulse_release();
    check("R3 load", 32'(wait_count), 3);
    edges(63);
    check("R2 before tick", 32'(wait_count), 3);
    edges(1);
    check("R2 first tick", 32'(wait_count), 2);
    edges(127);
    check("R4 no early stall", 32'(stall_flag), 0);
    check("R2 count at 191", 32'(wait_count), 1);
    edges(1);
    check("R4 stall flag", 32'(stall_flag), 1);
    check("R4 count reloaded", 32'(wait_count), 3);
    edges(100);
    check("R4 held", 32'(wait_count), 3);
    check("R8 no req in io", 32'(bus_req), 0);
    flag_write(1'b0);
    edges(2);
    check("R5 write 0 ignored", 32'(stall_flag), 1);
    flag_write(1'b1);
    check("R5 cleared", 32'(stall_flag), 0);
    edges(191);
    check("R6 no early restall", 32'(stall_flag), 0);
    check("R6 count", 32'(wait_count), 1);
    flag_write(1'b1);
    check("R5 set beats clear", 32'(stall_flag), 1);
    check("R6 reloaded", 32'(wait_count), 3);
  endtask

  // L = 2, second release in mid-period restarts the prescaler
  task automatic t_io_restart();
    do_reset();
    io_mode = 1'b1; stall_interval = 22'd128;
    pulse_release();
    edges(100);
    check("R2 count mid", 32'(wait_count), 1);
    pulse_release();
    check("R3 reload", 32'(wait_count), 2);
    edges(127);
    check("R3 prescaler restarted", 32'(stall_flag), 0);
    edges(1);
    check("R4 stall after restart", 32'(stall_flag), 1);
  endtask

  task automatic t_mem_delay();
    do_reset();
    io_mode = 1'b0; req_delay = 16'd5;
    pulse_release();
    check("R7 load", 32'(wait_count), 5);
    check("R8 no req yet", 32'(bus_req), 0);
    edges(3);
    check("R7 step", 32'(wait_count), 2);
    edges(2);
    check("R7 reach zero", 32'(wait_count), 0);
    check("R8 req", 32'(bus_req), 1);
    edges(2);
    check("R7 stop at zero", 32'(wait_count), 0);
    check("R8 req held", 32'(bus_req), 1);
    @(negedge clk);
    bus_grant = 1'b1;
    #1;
    check("R9 req drops", 32'(bus_req), 0);
    edges(1);
    bus_grant = 1'b0;
    edges(1);
    check("R9 req stays off", 32'(bus_req), 0);
  endtask

  task automatic t_mem_zero_grant();
    do_reset();
    io_mode = 1'b0; req_delay = 16'd10;
    pulse_release();
    edges(3);
    check("R7 count 7", 32'(wait_count), 7);
    @(negedge clk);
    bus_grant = 1'b1;
    edges(5);
    check("R9 frozen", 32'(wait_count), 7);
    check("R9 no req", 32'(bus_req), 0);
    @(negedge clk);
    bus_grant = 1'b0; req_delay = 16'd0;
    pulse_release();
    check("R8 zero delay req", 32'(bus_req), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_io_stall();
    t_io_restart();
    t_mem_delay();
    t_mem_zero_grant();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule